// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block picks which interrupt or trap the processor should take at the start of each instruction cycle. A one-cycle strobe marks the start of a cycle. On that strobe the block captures the request flags, the matching enable bits, a 3-bit priority for each interrupt source, and a small set of trap requests. During the next cycle it compares the enabled pending requests against the live processor priority level. One cycle later it presents the winner, which is one of these:

- a trap,
- an interrupt whose priority is strictly above the processor level,
- nothing.

For the winner it gives the source number, an effective 4-bit level and the word address of its vector. The address comes from either the default vector table or the alternate one, selected by a run-time switch.

Traps ignore the enable bits and the processor level. Among traps, the lowest trap number is the most urgent. Among interrupts, higher priority wins, and on a tie the lower interrupt number wins. The vector-memory fetch and the context save that follow a take are handled elsewhere.

Top module: `prio_vec_arbiter`

## Requirements
- R1: Inputs are captured on the clock edge where `cycStart` is 1. The result appears, together with a one-cycle `resValid` pulse, two edges later. Between pulses all result outputs hold their value.
- R2: An interrupt source counts as pending only when its captured flag bit and its captured enable bit are both 1.
- R3: An interrupt is taken only if its priority is strictly greater than `cpuLevel`, which is read in the cycle after the capture edge. A priority of 0 is therefore never taken.
- R4: Among the pending interrupts, the highest priority wins. On a tie, the lower interrupt number wins.
- R5: Any captured trap request is taken whatever the enables and `cpuLevel` are, and it outranks every interrupt. The lowest trap number wins, and `isTrap` is 1.
- R6: The level output is `{1'b0, prio}` for an interrupt and `15 - trapNumber` for a trap. Bit 3 of the level is therefore 1 only for traps.
- R7: In the default table, trap t sits at 0x000004 + 2*t and interrupt i at 0x000014 + 2*i. When `altSel` is 1 (read with `cpuLevel`), 0x80 is added to the address.
- R8: When nothing is taken, `irqTake`, `isTrap`, `vecNum`, `vecLevel` and `vecAddr` are all 0.
- R9: While `rstN` is 0, every output is 0.
- R10: Changes to flags, enables, priorities or traps made after the capture edge do not affect the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycStart | input | 1 | Instruction-cycle start strobe; capture on this edge |
| irqFlags | input | 54 | Interrupt request flags, bit i = source i |
| irqEnables | input | 54 | Interrupt enable bits, bit i = source i |
| irqPrioFlat | input | 162 | Per-source 3-bit priority, source i in bits [3i+2:3i] |
| trapReqs | input | 8 | Trap requests, bit t = trap t |
| cpuLevel | input | 3 | Current processor priority level |
| altSel | input | 1 | Select the alternate vector table |
| resValid | output | 1 | One-cycle pulse when a new result is presented |
| irqTake | output | 1 | A trap or interrupt is to be taken |
| isTrap | output | 1 | The winner is a trap |
| vecNum | output | 6 | Winning trap or interrupt number |
| vecLevel | output | 4 | Effective level of the winner |
| vecAddr | output | 24 | Vector word address of the winner |

## Verification
The assertions assume that `cpuLevel` and `altSel` stay stable from the capture edge until the result is presented. They also assume that `cycStart` is held low during reset. The bench drives inputs only at falling edges and holds the level and table select fixed across each capture-to-result window. It scrambles flags, enables, priorities and traps right after capture, so that the R10 isolation is exercised on every trial.

// File: rtl/prio_vec_pkg.sv
package prio_vec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take a snapshot of the request inputs
    logic latch;    // register the arbitration result
  } arbStrobes_t;
endpackage

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
  import prio_vec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycStart,
  output arbStrobes_t strobes,
  output logic        resValid
);
  logic evalPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evalPending <= 1'b0;
      resValid    <= 1'b0;
    end else begin
      evalPending <= cycStart;
      resValid    <= evalPending;
    end
  end

  always_comb begin
    strobes.capture = cycStart;
    strobes.latch   = evalPending;
  end
endmodule

// File: rtl/prio_vec_datapath.sv
module prio_vec_datapath
  import prio_vec_pkg::*;
#(
  parameter int NUM_IRQ    = 54,
  parameter int NUM_TRAP   = 8,
  parameter int PRIO_W     = 3,
  parameter int ADDR_W     = 24,
  parameter int TRAP_BASE  = 4,
  parameter int ALT_OFFSET = 128,
  localparam int NUM_W     = $clog2((NUM_IRQ > NUM_TRAP) ? NUM_IRQ : NUM_TRAP),
  localparam int LVL_W     = PRIO_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  arbStrobes_t              strobes,
  input  logic [NUM_IRQ-1:0]       irqFlags,
  input  logic [NUM_IRQ-1:0]       irqEnables,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrioFlat,
  input  logic [NUM_TRAP-1:0]      trapReqs,
  input  logic [PRIO_W-1:0]        cpuLevel,
  input  logic                     altSel,
  output logic                     irqTake,
  output logic                     isTrap,
  output logic [NUM_W-1:0]         vecNum,
  output logic [LVL_W-1:0]         vecLevel,
  output logic [ADDR_W-1:0]        vecAddr
);
  localparam int IRQ_BASE = TRAP_BASE + 2 * NUM_TRAP;
  localparam int LVL_MAX  = (1 << LVL_W) - 1;

  logic [NUM_IRQ-1:0]        flagQ, enableQ;
  logic [NUM_IRQ*PRIO_W-1:0] prioQ;
  logic [NUM_TRAP-1:0]       trapQ;
  logic [NUM_IRQ-1:0]        pendQ;
  logic [PRIO_W-1:0]         prioArr [NUM_IRQ];

  // snapshot at the start of the instruction cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= '0;
      enableQ <= '0;
      prioQ   <= '0;
      trapQ   <= '0;
    end else if (strobes.capture) begin
      flagQ   <= irqFlags;
      enableQ <= irqEnables;
      prioQ   <= irqPrioFlat;
      trapQ   <= trapReqs;
    end
  end

  assign pendQ = flagQ & enableQ;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_prio
      assign prioArr[g] = prioQ[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  // interrupt scan: strict greater keeps the lower index on ties
  logic              irqFound;
  logic [PRIO_W-1:0] irqBestPrio;
  logic [NUM_W-1:0]  irqBestIdx;

  always_comb begin
    irqFound    = 1'b0;
    irqBestPrio = '0;
    irqBestIdx  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pendQ[i] && (!irqFound || (prioArr[i] > irqBestPrio))) begin
        irqFound    = 1'b1;
        irqBestPrio = prioArr[i];
        irqBestIdx  = NUM_W'(i);
      end
    end
  end

  // trap scan: lowest index wins
  logic             trapFound;
  logic [NUM_W-1:0] trapIdx;

  always_comb begin
    trapFound = 1'b0;
    trapIdx   = '0;
    for (int t = NUM_TRAP - 1; t >= 0; t--) begin
      if (trapQ[t]) begin
        trapFound = 1'b1;
        trapIdx   = NUM_W'(t);
      end
    end
  end

  logic              irqWins;
  logic [ADDR_W-1:0] tableOffset;
  logic              nTake, nTrap;
  logic [NUM_W-1:0]  nNum;
  logic [LVL_W-1:0]  nLevel;
  logic [ADDR_W-1:0] nAddr;

  assign irqWins     = irqFound && (irqBestPrio > cpuLevel);
  assign tableOffset = altSel ? ADDR_W'(ALT_OFFSET) : '0;

  always_comb begin
    nTake  = 1'b0;
    nTrap  = 1'b0;
    nNum   = '0;
    nLevel = '0;
    nAddr  = '0;
    if (trapFound) begin
      nTake  = 1'b1;
      nTrap  = 1'b1;
      nNum   = trapIdx;
      nLevel = LVL_W'(LVL_MAX) - LVL_W'(trapIdx);
      nAddr  = ADDR_W'(TRAP_BASE) + (ADDR_W'(trapIdx) << 1) + tableOffset;
    end else if (irqWins) begin
      nTake  = 1'b1;
      nNum   = irqBestIdx;
      nLevel = {1'b0, irqBestPrio};
      nAddr  = ADDR_W'(IRQ_BASE) + (ADDR_W'(irqBestIdx) << 1) + tableOffset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqTake  <= 1'b0;
      isTrap   <= 1'b0;
      vecNum   <= '0;
      vecLevel <= '0;
      vecAddr  <= '0;
    end else if (strobes.latch) begin
      irqTake  <= nTake;
      isTrap   <= nTrap;
      vecNum   <= nNum;
      vecLevel <= nLevel;
      vecAddr  <= nAddr;
    end
  end
endmodule

// File: rtl/prio_vec_arbiter.sv
module prio_vec_arbiter
  import prio_vec_pkg::*;
#(
  parameter int NUM_IRQ    = 54,
  parameter int NUM_TRAP   = 8,
  parameter int PRIO_W     = 3,
  parameter int ADDR_W     = 24,
  parameter int TRAP_BASE  = 4,
  parameter int ALT_OFFSET = 128,
  localparam int NUM_W     = $clog2((NUM_IRQ > NUM_TRAP) ? NUM_IRQ : NUM_TRAP),
  localparam int LVL_W     = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cycStart,
  input  logic [NUM_IRQ-1:0]        irqFlags,
  input  logic [NUM_IRQ-1:0]        irqEnables,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrioFlat,
  input  logic [NUM_TRAP-1:0]       trapReqs,
  input  logic [PRIO_W-1:0]         cpuLevel,
  input  logic                      altSel,
  output logic                      resValid,
  output logic                      irqTake,
  output logic                      isTrap,
  output logic [NUM_W-1:0]          vecNum,
  output logic [LVL_W-1:0]          vecLevel,
  output logic [ADDR_W-1:0]         vecAddr
);
  arbStrobes_t strobes;

  prio_vec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .strobes  (strobes),
    .resValid (resValid)
  );

  prio_vec_datapath #(
    .NUM_IRQ    (NUM_IRQ),
    .NUM_TRAP   (NUM_TRAP),
    .PRIO_W     (PRIO_W),
    .ADDR_W     (ADDR_W),
    .TRAP_BASE  (TRAP_BASE),
    .ALT_OFFSET (ALT_OFFSET)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .irqFlags    (irqFlags),
    .irqEnables  (irqEnables),
    .irqPrioFlat (irqPrioFlat),
    .trapReqs    (trapReqs),
    .cpuLevel    (cpuLevel),
    .altSel      (altSel),
    .irqTake     (irqTake),
    .isTrap      (isTrap),
    .vecNum      (vecNum),
    .vecLevel    (vecLevel),
    .vecAddr     (vecAddr)
  );
endmodule

// File: rtl/prio_vec_arbiter_checker.sv
module prio_vec_arbiter_checker #(
  parameter int NUM_TRAP   = 8,
  parameter int NUM_W      = 6,
  parameter int LVL_W      = 4,
  parameter int PRIO_W     = 3,
  parameter int ADDR_W     = 24,
  parameter int ALT_OFFSET = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycStart,
  input logic [PRIO_W-1:0] cpuLevel,
  input logic              altSel,
  input logic              resValid,
  input logic              irqTake,
  input logic              isTrap,
  input logic [NUM_W-1:0]  vecNum,
  input logic [LVL_W-1:0]  vecLevel,
  input logic [ADDR_W-1:0] vecAddr
);
  // R1: a capture edge is followed two edges later by the result pulse
  p_result_timing_r1: assert property (@(posedge clk) disable iff (!rstN)
    cycStart |-> ##2 resValid);

  // R1: outputs only move on a result pulse
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(vecAddr) && $stable(irqTake) && $stable(vecNum)));

  // R3: a taken interrupt sits strictly above the level read in the eval cycle
  p_above_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && irqTake && !isTrap) |-> (vecLevel[PRIO_W-1:0] > $past(cpuLevel)));

  // R6: the top level bit marks traps only
  p_trap_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (vecLevel[LVL_W-1] == isTrap));

  // R5: trap numbers stay inside the trap range
  p_trap_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && isTrap) |-> (vecNum < NUM_W'(NUM_TRAP)));

  // R7: table choice follows the select read in the eval cycle
  p_table_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && irqTake) |-> ((vecAddr >= ADDR_W'(ALT_OFFSET)) == $past(altSel)));

  // R8: an empty result carries no vector
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqTake |-> (vecAddr == '0 && vecLevel == '0 && !isTrap));
endmodule

bind prio_vec_arbiter prio_vec_arbiter_checker #(
  .NUM_TRAP   (NUM_TRAP),
  .NUM_W      (NUM_W),
  .LVL_W      (LVL_W),
  .PRIO_W     (PRIO_W),
  .ADDR_W     (ADDR_W),
  .ALT_OFFSET (ALT_OFFSET)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cycStart (cycStart),
  .cpuLevel (cpuLevel),
  .altSel   (altSel),
  .resValid (resValid),
  .irqTake  (irqTake),
  .isTrap   (isTrap),
  .vecNum   (vecNum),
  .vecLevel (vecLevel),
  .vecAddr  (vecAddr)
);

// File: tb/prio_vec_arbiter_bench.sv
module prio_vec_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 54;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cycStart = 1'b0;
  logic [NI-1:0] irqFlags = '0, irqEnables = '0;
  logic [NI*3-1:0] irqPrioFlat = '0;
  logic [NT-1:0] trapReqs = '0;
  logic [2:0]    cpuLevel = '0;
  logic          altSel = 1'b0;
  logic          resValid, irqTake, isTrap;
  logic [5:0]    vecNum;
  logic [3:0]    vecLevel;
  logic [23:0]   vecAddr;

  int checks = 0;
  int failures = 0;

  logic          expTake, expTrap;
  int            expNum, expLevel, expAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_arbiter u_prio_vec_arbiter (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .irqFlags(irqFlags),
    .irqEnables(irqEnables), .irqPrioFlat(irqPrioFlat), .trapReqs(trapReqs),
    .cpuLevel(cpuLevel), .altSel(altSel), .resValid(resValid), .irqTake(irqTake),
    .isTrap(isTrap), .vecNum(vecNum), .vecLevel(vecLevel), .vecAddr(vecAddr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic computeExpected(input logic [NI-1:0] f, input logic [NI-1:0] e,
                                 input logic [NI*3-1:0] p, input logic [NT-1:0] tr,
                                 input logic [2:0] lvl, input logic alt);
    int bestI = -1;
    int bestP = -1;
    int trapI = -1;
    for (int t = 0; t < NT; t++) if (tr[t] && trapI < 0) trapI = t;
    for (int i = 0; i < NI; i++) begin
      int pr = int'(p[i*3 +: 3]);
      if (f[i] && e[i] && pr > bestP) begin bestP = pr; bestI = i; end
    end
    expTake = 0; expTrap = 0; expNum = 0; expLevel = 0; expAddr = 0;
    if (trapI >= 0) begin
      expTake = 1; expTrap = 1; expNum = trapI; expLevel = 15 - trapI;
      expAddr = 4 + 2 * trapI + (alt ? 128 : 0);
    end else if (bestI >= 0 && bestP > int'(lvl)) begin
      expTake = 1; expNum = bestI; expLevel = bestP;
      expAddr = 20 + 2 * bestI + (alt ? 128 : 0);
    end
  endtask

  task automatic trial(input string req, input logic [NI-1:0] f, input logic [NI-1:0] e,
                       input logic [NI*3-1:0] p, input logic [NT-1:0] tr,
                       input logic [2:0] lvl, input logic alt, input bit checkHold);
    computeExpected(f, e, p, tr, lvl, alt);
    @(negedge clk);
    irqFlags = f; irqEnables = e; irqPrioFlat = p; trapReqs = tr;
    cpuLevel = lvl; altSel = alt; cycStart = 1'b1;
    @(negedge clk);
    cycStart = 1'b0;
    // R10: scramble the request inputs after capture
    irqFlags = ~f; irqEnables = ~e; irqPrioFlat = ~p; trapReqs = ~tr;
    @(negedge clk);
    check("R1", "resValid", int'(resValid), 1);
    check(req, "irqTake", int'(irqTake), int'(expTake));
    check(req, "isTrap", int'(isTrap), int'(expTrap));
    check(req, "vecNum", int'(vecNum), expNum);
    check(req, "vecLevel", int'(vecLevel), expLevel);
    check(req, "vecAddr", int'(vecAddr), expAddr);
    if (checkHold) begin
      @(negedge clk);
      check("R1", "resValid after pulse", int'(resValid), 0);
      check("R1", "vecAddr held", int'(vecAddr), expAddr);
    end
  endtask

  function automatic logic [NI*3-1:0] uniformPrio(input int v);
    logic [NI*3-1:0] r;
    for (int i = 0; i < NI; i++) r[i*3 +: 3] = 3'(v);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NI-1:0] f, e, ones;
    logic [NI*3-1:0] p;
    int unused;
    unused = $urandom(32'd20240611);
    ones = '1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "resValid", int'(resValid), 0);
    check("R9", "irqTake", int'(irqTake), 0);
    check("R9", "vecAddr", int'(vecAddr), 0);
    check("R9", "vecLevel", int'(vecLevel), 0);
    rstN = 1'b1;

    // R3: priority 0 never taken, equal level not taken
    p = uniformPrio(0);
    trial("R3", NI'(1) << 5, ones, p, '0, 3'd0, 1'b0, 1'b1);
    p = uniformPrio(4);
    trial("R3", NI'(1) << 9, ones, p, '0, 3'd4, 1'b0, 1'b0);
    trial("R3", NI'(1) << 9, ones, p, '0, 3'd3, 1'b0, 1'b0);
    // R2: flag without enable
    trial("R2", NI'(1) << 12, ~(NI'(1) << 12), p, '0, 3'd0, 1'b0, 1'b0);
    // R4: tie lower number wins; higher priority beats lower number
    p = uniformPrio(5);
    trial("R4", (NI'(1) << 30) | (NI'(1) << 17), ones, p, '0, 3'd1, 1'b0, 1'b0);
    p[40*3 +: 3] = 3'd7;
    trial("R4", (NI'(1) << 40) | (NI'(1) << 2), ones, p, '0, 3'd1, 1'b0, 1'b0);
    // R5/R6: traps ignore enables and level
    trial("R5", ones, '0, uniformPrio(7), 8'b0110_0000, 3'd7, 1'b0, 1'b1);
    trial("R6", '0, '0, p, 8'b1000_0001, 3'd7, 1'b1, 1'b0);
    // R7: table edges
    p = uniformPrio(1);
    trial("R7", NI'(1) << 53, ones, p, '0, 3'd0, 1'b1, 1'b0);
    trial("R7", NI'(1) << 0, ones, p, '0, 3'd0, 1'b0, 1'b0);
    trial("R7", '0, '0, p, 8'b1000_0000, 3'd0, 1'b1, 1'b0);
    // R8: nothing pending
    trial("R8", '0, ones, p, '0, 3'd0, 1'b1, 1'b1);

    // random trials (R10 scramble included in every trial)
    for (int n = 0; n < 400; n++) begin
      logic [NT-1:0] tr;
      f = {$urandom, $urandom} & ((n % 3 == 0) ? {$urandom, $urandom} : '1);
      e = {$urandom, $urandom} | ((n % 5 == 0) ? '1 : '0);
      for (int i = 0; i < NI; i++) p[i*3 +: 3] = 3'($urandom);
      tr = (($urandom % 8) == 0) ? 8'($urandom) : '0;
      trial("R4", f, e, p, tr, 3'($urandom), 1'($urandom), (n % 7) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule